// File: doc/BRIEF.md
# Pulse Tone Channel with Frequency Sweep

This block generates one square-wave voice for a sound subsystem. A small register file sets the pulse shape, the pitch, the loudness ramp, the note duration and an automatic pitch glide. A trigger bit in the control register starts a note. From then on, four timed units work together on every clock:

- a duty sequencer, driven by a frequency timer, steps through an 8-step high/low pattern;
- a length counter can end the note;
- a volume envelope ramps the 4-bit level up or down;
- a sweep unit periodically shifts the pitch up or down.

The block emits a 4-bit amplitude sample each cycle and a flag that tells whether the voice is still sounding. Mixing, panning and conversion to analogue happen elsewhere.

The register write port is a plain strobe with no back-pressure. A write is accepted in any cycle in which `reg_wr_en` is high, and it takes effect at that clock edge. The three tick inputs are single-cycle strobes from an external frame sequencer:

- the length tick runs at 256 Hz;
- the sweep tick runs at 128 Hz;
- the envelope tick runs at 64 Hz.

There is no data stream, so no valid/ready handshake applies.

Register map (`reg_wr_addr`):
- 0: sweep. Bits 6:4 are the sweep period, bit 3 selects the direction (0 add, 1 subtract), bits 2:0 are the shift.
- 1: shape. Bits 7:6 are the duty code, bits 5:0 are the length value L.
- 2: envelope. Bits 7:4 are the start volume, bit 3 selects the direction (1 up, 0 down), bits 2:0 are the envelope period.
- 3: frequency bits 7:0.
- 4: control. Bit 7 is the trigger, bit 6 is the length enable, bits 2:0 are frequency bits 10:8.

Top module: `pulse_tone_channel`

## Requirements
- R1: After reset, `amp_out` is 0 and `chan_active` is 0.
- R2: Duty codes 0, 1, 2 and 3 (shape bits 7:6) select these step patterns, listed from step 0 to step 7:
  - code 0: 00000001;
  - code 1: 10000001;
  - code 2: 10000111;
  - code 3: 01111110.

  Over one full pattern with constant volume, the channel is high for 1, 2, 4 and 6 steps respectively.
- R3: The duty step advances once every (2048 - F) * 4 clocks, where F is the 11-bit frequency {control[2:0], freq_low}.
- R4: A write to address 4 with bit 7 set has these effects at that edge:
  - `chan_active` is set;
  - the volume loads the envelope start value;
  - the envelope and sweep counters reload;
  - the duty sequence restarts at step 0 with a fresh timer computed from the frequency being written.
- R5: Writing the shape register loads the length counter with 64 - L. While control bit 6 is 1, each length tick decrements a nonzero counter, and the tick that reaches 0 clears `chan_active`. A trigger on a zero counter reloads it to 64.
- R6: With an envelope period P from 1 to 7, the volume moves by 1 on every P-th envelope tick after the trigger: up if bit 3 is 1, down if bit 3 is 0.
- R7: The volume saturates at 15 going up and at 0 going down. With envelope period 0, envelope ticks leave the volume unchanged.
- R8: With sweep period S from 1 to 7 and shift N from 1 to 7, every S-th sweep tick replaces the internal sweep frequency X and the channel frequency with X + (X >> N), or with X - (X >> N) in subtract mode. X is captured from the frequency at trigger.
- R9: A sweep result above 2047 clears `chan_active`. With sweep period 0 or shift 0, sweep ticks change neither the frequency nor the active flag.
- R10: `amp_out` equals the current volume when the channel is active and the current duty step is 1; otherwise it is 0.
- R11: While control bit 6 is 0, length ticks have no effect on `chan_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register select (0 to 4) |
| reg_wr_data | input | 8 | Register write value |
| tick_len | input | 1 | 256 Hz length strobe |
| tick_sweep | input | 1 | 128 Hz sweep strobe |
| tick_env | input | 1 | 64 Hz envelope strobe |
| amp_out | output | 4 | Amplitude sample |
| chan_active | output | 1 | Voice is sounding |

## Verification
The faults each show at the ports as follows:
- A wrong duty step or timer value shows in `amp_out` within a few clocks at the highest pitches used, as a high phase that is shifted or has the wrong width.
- A wrong volume shows in the height of the next high phase after an envelope tick.
- A wrong length count or sweep shadow only becomes visible at the tick that should, or should not, clear `chan_active`. For that reason the sequences drive those units exactly up to and past their expiry point.

The reference model is compared with both outputs on every clock, so a divergence is reported in the cycle where it first reaches a port.

// File: rtl/pulse_pkg.sv
package pulse_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;
  localparam int FREQ_W = 11;
  localparam int LEN_W  = 6;
  localparam int VOL_W  = 4;
  localparam int PER_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SWEEP = 3'd0,
    A_SHAPE = 3'd1,
    A_ENV   = 3'd2,
    A_FLO   = 3'd3,
    A_CTL   = 3'd4
  } reg_addr_e;

  // Bit s of the pattern is the level of step s.
  function automatic logic duty_level(input logic [1:0] sel, input logic [2:0] step);
    logic [7:0] pat;
    case (sel)
      2'd0:    pat = 8'b1000_0000;
      2'd1:    pat = 8'b1000_0001;
      2'd2:    pat = 8'b1110_0001;
      default: pat = 8'b0111_1110;
    endcase
    return pat[step];
  endfunction
endpackage

// File: rtl/pulse_duty_seq.sv
module pulse_duty_seq import pulse_pkg::*; #(
  parameter int FW = FREQ_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [FW-1:0] trig_freq,
  input  logic [FW-1:0] run_freq,
  input  logic [1:0]    duty_sel,
  output logic          duty_bit
);
  localparam int TMR_W = FW + 3;

  logic [TMR_W-1:0] timer;
  logic [2:0]       pos;

  function automatic logic [TMR_W-1:0] reload(input logic [FW-1:0] f);
    logic [TMR_W-1:0] base;
    base = (TMR_W'(1) << FW) - TMR_W'(f);
    return base << 2;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer <= reload('0);
      pos   <= '0;
    end else if (trig) begin
      timer <= reload(trig_freq);
      pos   <= '0;
    end else if (timer == TMR_W'(1)) begin
      timer <= reload(run_freq);
      pos   <= pos + 3'd1;
    end else begin
      timer <= timer - TMR_W'(1);
    end
  end

  assign duty_bit = duty_level(duty_sel, pos);

  // R3
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && timer != TMR_W'(1)) |=> $stable(pos));
endmodule

// File: rtl/pulse_len_ctr.sv
module pulse_len_ctr import pulse_pkg::*; #(
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] load_val,
  input  logic          trig,
  input  logic          tick,
  input  logic          enable,
  output logic          kill
);
  localparam int CW = LW + 1;
  localparam logic [CW-1:0] FULL = CW'(1) << LW;

  logic [CW-1:0] cnt;

  assign kill = tick && enable && cnt == CW'(1) && !trig && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= FULL - CW'(load_val);
    end else if (trig) begin
      if (cnt == '0) cnt <= FULL;
    end else if (tick && enable && cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  // R5
  len_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !trig) |=> cnt <= $past(cnt));
endmodule

// File: rtl/pulse_env.sv
module pulse_env import pulse_pkg::*; #(
  parameter int VW = VOL_W,
  parameter int PW = PER_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          tick,
  input  logic [VW-1:0] init,
  input  logic          up,
  input  logic [PW-1:0] period,
  output logic [VW-1:0] vol
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol <= '0;
      cnt <= '0;
    end else if (trig) begin
      vol <= init;
      cnt <= period;
    end else if (tick && period != '0) begin
      if (cnt <= PW'(1)) begin
        cnt <= period;
        if (up && vol != '1)         vol <= vol + VW'(1);
        else if (!up && vol != '0)   vol <= vol - VW'(1);
      end else begin
        cnt <= cnt - PW'(1);
      end
    end
  end

  // R7
  env_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period == '0 && !trig) |=> $stable(vol));
endmodule

// File: rtl/pulse_sweep.sv
module pulse_sweep import pulse_pkg::*; #(
  parameter int FW = FREQ_W,
  parameter int PW = PER_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [FW-1:0] trig_freq,
  input  logic          tick,
  input  logic [PW-1:0] period,
  input  logic          sub,
  input  logic [2:0]    shift,
  output logic          upd,
  output logic [FW-1:0] new_freq,
  output logic          kill
);
  logic [FW-1:0] shadow;
  logic [PW-1:0] cnt;
  logic [FW:0]   sum;
  logic          fire;

  always_comb begin
    if (sub) sum = {1'b0, shadow} - {1'b0, shadow >> shift};
    else     sum = {1'b0, shadow} + {1'b0, shadow >> shift};
  end

  assign fire     = tick && period != '0 && cnt <= PW'(1) && !trig;
  assign upd      = fire && shift != '0 && !sum[FW];
  assign kill     = fire && shift != '0 && sum[FW];
  assign new_freq = sum[FW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      cnt    <= '0;
    end else if (trig) begin
      shadow <= trig_freq;
      cnt    <= period;
    end else if (tick && period != '0) begin
      if (cnt <= PW'(1)) begin
        cnt <= period;
        if (upd) shadow <= new_freq;
      end else begin
        cnt <= cnt - PW'(1);
      end
    end
  end

  // R9
  sweep_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && sub) |-> new_freq <= shadow);
endmodule

// File: rtl/pulse_tone_channel.sv
module pulse_tone_channel import pulse_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [REG_W-1:0]  reg_wr_data,
  input  logic              tick_len,
  input  logic              tick_sweep,
  input  logic              tick_env,
  output logic [VOL_W-1:0]  amp_out,
  output logic              chan_active
);
  localparam int HI_W = FREQ_W - REG_W;

  logic wr_sweep, wr_shape, wr_env, wr_flo, wr_ctl, trig;
  logic [6:0]        sweep_cfg;
  logic [1:0]        duty_sel;
  logic [REG_W-1:0]  env_cfg;
  logic [FREQ_W-1:0] freq, trig_freq, sw_freq;
  logic              len_en, len_kill, sw_kill, sw_upd, duty_bit;
  logic [VOL_W-1:0]  vol;

  assign wr_sweep  = reg_wr_en && reg_wr_addr == A_SWEEP;
  assign wr_shape  = reg_wr_en && reg_wr_addr == A_SHAPE;
  assign wr_env    = reg_wr_en && reg_wr_addr == A_ENV;
  assign wr_flo    = reg_wr_en && reg_wr_addr == A_FLO;
  assign wr_ctl    = reg_wr_en && reg_wr_addr == A_CTL;
  assign trig      = wr_ctl && reg_wr_data[7];
  assign trig_freq = {reg_wr_data[HI_W-1:0], freq[REG_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sweep_cfg   <= '0;
      duty_sel    <= '0;
      env_cfg     <= '0;
      freq        <= '0;
      len_en      <= 1'b0;
      chan_active <= 1'b0;
    end else begin
      if (sw_upd)   freq <= sw_freq;
      if (wr_flo)   freq[REG_W-1:0] <= reg_wr_data;
      if (wr_ctl) begin
        freq[FREQ_W-1:REG_W] <= reg_wr_data[HI_W-1:0];
        len_en <= reg_wr_data[6];
      end
      if (wr_shape) duty_sel  <= reg_wr_data[7:6];
      if (wr_env)   env_cfg   <= reg_wr_data;
      if (wr_sweep) sweep_cfg <= reg_wr_data[6:0];
      if (trig)                     chan_active <= 1'b1;
      else if (len_kill || sw_kill) chan_active <= 1'b0;
    end
  end

  pulse_duty_seq u_duty (
    .clk(clk), .rst_n(rst_n), .trig(trig), .trig_freq(trig_freq),
    .run_freq(freq), .duty_sel(duty_sel), .duty_bit(duty_bit)
  );

  pulse_len_ctr u_len (
    .clk(clk), .rst_n(rst_n), .load(wr_shape), .load_val(reg_wr_data[LEN_W-1:0]),
    .trig(trig), .tick(tick_len), .enable(len_en), .kill(len_kill)
  );

  pulse_env u_env (
    .clk(clk), .rst_n(rst_n), .trig(trig), .tick(tick_env),
    .init(env_cfg[7:4]), .up(env_cfg[3]), .period(env_cfg[2:0]), .vol(vol)
  );

  pulse_sweep u_sweep (
    .clk(clk), .rst_n(rst_n), .trig(trig), .trig_freq(trig_freq),
    .tick(tick_sweep), .period(sweep_cfg[6:4]), .sub(sweep_cfg[3]),
    .shift(sweep_cfg[2:0]), .upd(sw_upd), .new_freq(sw_freq), .kill(sw_kill)
  );

  assign amp_out = (chan_active && duty_bit) ? vol : '0;

  // R4
  trig_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> chan_active);
endmodule

// File: tb/pulse_tone_channel_tb.sv
module pulse_tone_channel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic t_len = 1'b0, t_sw = 1'b0, t_env = 1'b0;
  logic [3:0] amp;
  logic act;

  int checks = 0, bad = 0;

  always #10 clk = ~clk;

  pulse_tone_channel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr),
    .reg_wr_data(wr_data), .tick_len(t_len), .tick_sweep(t_sw), .tick_env(t_env),
    .amp_out(amp), .chan_active(act)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // Behavioural reference model
  int m_sw, m_duty, m_env, m_freq, m_len_en, m_act;
  int m_tmr, m_pos, m_len, m_vol, m_ecnt, m_shadow, m_scnt;

  function automatic int pattern_hi(int code, int step);
    string p;
    case (code)
      0: p = "00000001";
      1: p = "10000001";
      2: p = "10000111";
      default: p = "01111110";
    endcase
    return (p[step] == "1") ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sw = 0; m_duty = 0; m_env = 0; m_freq = 0; m_len_en = 0; m_act = 0;
      m_tmr = 8192; m_pos = 0; m_len = 0; m_vol = 0; m_ecnt = 0; m_shadow = 0; m_scnt = 0;
    end else begin
      int trig, tf, kill, upd, nf, n_tmr, n_pos, n_len, n_vol, n_ecnt, n_sh, n_scnt;
      int ep, sp, sh, d, nv;
      trig = (wr_en && wr_addr == 4 && wr_data[7]) ? 1 : 0;
      tf = (wr_data & 7) * 256 + (m_freq % 256);
      kill = 0; upd = 0; nf = 0;
      n_tmr = m_tmr; n_pos = m_pos; n_len = m_len; n_vol = m_vol;
      n_ecnt = m_ecnt; n_sh = m_shadow; n_scnt = m_scnt;
      if (trig) begin n_tmr = (2048 - tf) * 4; n_pos = 0; end
      else if (m_tmr == 1) begin n_tmr = (2048 - m_freq) * 4; n_pos = (m_pos + 1) % 8; end
      else n_tmr = m_tmr - 1;
      if (wr_en && wr_addr == 1) n_len = 64 - (wr_data & 63);
      else if (trig) begin if (m_len == 0) n_len = 64; end
      else if (t_len && m_len_en && m_len > 0) begin
        n_len = m_len - 1;
        if (m_len == 1) kill = 1;
      end
      ep = m_env & 7;
      if (trig) begin n_vol = m_env / 16; n_ecnt = ep; end
      else if (t_env && ep != 0) begin
        if (m_ecnt <= 1) begin
          n_ecnt = ep;
          if ((m_env & 8) != 0) begin if (m_vol < 15) n_vol = m_vol + 1; end
          else if (m_vol > 0) n_vol = m_vol - 1;
        end else n_ecnt = m_ecnt - 1;
      end
      sp = (m_sw / 16) & 7; sh = m_sw & 7;
      if (trig) begin n_sh = tf; n_scnt = sp; end
      else if (t_sw && sp != 0) begin
        if (m_scnt <= 1) begin
          n_scnt = sp;
          if (sh != 0) begin
            d = m_shadow >> sh;
            nv = ((m_sw & 8) != 0) ? m_shadow - d : m_shadow + d;
            if (nv > 2047) kill = 1;
            else begin n_sh = nv; upd = 1; nf = nv; end
          end
        end else n_scnt = m_scnt - 1;
      end
      if (upd) m_freq = nf;
      if (wr_en) begin
        case (wr_addr)
          0: m_sw = wr_data;
          1: m_duty = wr_data / 64;
          2: m_env = wr_data;
          3: m_freq = (m_freq / 256) * 256 + wr_data;
          4: begin m_freq = (wr_data & 7) * 256 + (m_freq % 256); m_len_en = wr_data[6]; end
          default: ;
        endcase
      end
      if (trig) m_act = 1; else if (kill) m_act = 0;
      m_tmr = n_tmr; m_pos = n_pos; m_len = n_len; m_vol = n_vol;
      m_ecnt = n_ecnt; m_shadow = n_sh; m_scnt = n_scnt;
    end
  end

  // Compare on every clock, after the edge has settled
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R10 amp_out vs model", amp, (m_act && pattern_hi(m_duty, m_pos)) ? m_vol : 0);
      chk("R4 chan_active vs model", act, m_act);
    end
  end

  task automatic wr(input int a, input int v);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(v);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick(input int which);
    @(negedge clk);
    if (which == 0) t_len = 1'b1; else if (which == 1) t_sw = 1'b1; else t_env = 1'b1;
    @(negedge clk); t_len = 1'b0; t_sw = 1'b0; t_env = 1'b0;
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (amp != 0) c++;
      @(negedge clk);
    end
  endtask

  task automatic max_amp(output int m);
    m = 0;
    for (int i = 0; i < 32; i++) begin
      if (amp > m) m = amp;
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    summary();
  end

  initial begin
    int c, m;
    repeat (3) @(negedge clk);
    chk("R1 amp after reset", amp, 0);
    chk("R1 active after reset", act, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 amp idle", amp, 0);

    // R2: duty codes at F=2047 (4 clocks per step), volume 15, no envelope
    wr(2, 8'hF0); wr(3, 8'hFF);
    for (int d = 0; d < 4; d++) begin
      wr(1, d * 64);
      wr(4, 8'h87);
      count_high(32, c);
      chk($sformatf("R2 high clocks duty %0d", d), c, (d == 0) ? 4 : (d == 1) ? 8 : (d == 2) ? 16 : 24);
    end

    // R3: F=2046 gives 8 clocks per step
    wr(1, 8'h00); wr(3, 8'hFE); wr(4, 8'h87);
    count_high(56, c);
    chk("R3 low during steps 0-6", c, 0);
    count_high(8, c);
    chk("R3 high step 7 width", c, 8);

    // R5: L=62 -> two ticks to expire
    wr(3, 8'hFF); wr(1, 8'hFE); wr(4, 8'hC7);
    tick(0);
    chk("R5 active after first length tick", act, 1);
    tick(0);
    chk("R5 expired after second length tick", act, 0);
    count_high(16, c);
    chk("R10 silent when inactive", c, 0);
    // R11: retrigger with length disabled, counter reloads and ticks ignored
    wr(4, 8'h87);
    for (int i = 0; i < 3; i++) tick(0);
    chk("R11 length ticks ignored", act, 1);
    // R5: L=0 -> 64 ticks
    wr(1, 8'hC0); wr(4, 8'hC7);
    for (int i = 0; i < 63; i++) tick(0);
    chk("R5 active after 63 ticks", act, 1);
    tick(0);
    chk("R5 expired after 64 ticks", act, 0);

    // R6: start 0, up, period 2; four ticks -> volume 2
    wr(1, 8'hC0); wr(2, 8'h0A); wr(4, 8'h87);
    for (int i = 0; i < 4; i++) tick(2);
    max_amp(m);
    chk("R6 envelope up after 4 ticks", m, 2);
    // R7: saturation up and down, period 0 hold
    wr(2, 8'hE9); wr(4, 8'h87);
    for (int i = 0; i < 3; i++) tick(2);
    max_amp(m);
    chk("R7 saturate at 15", m, 15);
    wr(2, 8'h31); wr(4, 8'h87);
    for (int i = 0; i < 2; i++) tick(2);
    max_amp(m);
    chk("R6 envelope down", m, 1);
    for (int i = 0; i < 3; i++) tick(2);
    max_amp(m);
    chk("R7 saturate at 0", m, 0);
    chk("R7 zero volume keeps active", act, 1);
    wr(2, 8'h50); wr(4, 8'h87);
    for (int i = 0; i < 3; i++) tick(2);
    max_amp(m);
    chk("R7 period 0 holds volume", m, 5);

    // R8: add, shift 1, period 2 from 1024: 1536 at tick 2, overflow at tick 4
    wr(2, 8'hF0); wr(0, 8'h21); wr(3, 8'h00); wr(4, 8'h84);
    for (int i = 0; i < 3; i++) tick(1);
    chk("R8 still active after 3 sweep ticks", act, 1);
    tick(1);
    chk("R8 overflow after shadow update", act, 0);
    // R9: period 1 overflows on the second tick
    wr(0, 8'h11); wr(4, 8'h84);
    tick(1);
    chk("R9 active after first sweep", act, 1);
    tick(1);
    chk("R9 overflow kills", act, 0);
    // R9: shift 0 and period 0 leave the channel alone
    wr(0, 8'h10); wr(3, 8'hFF); wr(4, 8'h87);
    for (int i = 0; i < 3; i++) tick(1);
    chk("R9 shift 0 no update", act, 1);
    count_high(32, c);
    chk("R9 shift 0 keeps pitch", c, 24);
    wr(0, 8'h07); wr(4, 8'h87);
    for (int i = 0; i < 3; i++) tick(1);
    chk("R9 period 0 no update", act, 1);
    // R8: subtract from 2040, shift 7 -> 2025; model tracks new pitch
    wr(0, 8'h1F); wr(3, 8'hF8); wr(4, 8'h87);
    tick(1);
    count_high(400, c);
    chk("R8 subtract keeps active", act, 1);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule